// File: doc/BRIEF.md
# Snoop and Tag-Port Arbitration Controller

This block watches a shared external bus and checks snooped addresses against a data-cache tag array that has only one port. It keeps that array inside itself: 4 ways, 128 sets, 32-byte lines and 32-bit physical addresses. The tag is address bits 31:12 and the set index is bits 11:5. Each cycle, the controller gives the single port to one user. A line-install write from the fill side comes first. A qualified bus snoop comes next. The processor's own load or store lookup comes last.

A snoop may be answered in one of three ways: it is ignored, it is serviced under the MEI protocol, or it is retried. A snoop is retried when it runs into a tag write, an active burst, a snoop still in flight, or a modified line that is already moving into the copyback buffer. In that last case, the block also raises the cast-out's bus priority ahead of the held line fill. When a modified line is hit, the block requests a snoop push of that line.

Top module: `snoop_tag_arbiter`

## Requirements
- R1: A snoop is qualified only when `bus_ts` and `bus_gbl` are both high in the same cycle. Any other bus cycle causes no retry, no push and no change to any line state.
- R2: When a qualified snoop takes the tag port, a core request in that same cycle sees `core_stall` high. The core lookup proceeds on the next clock. `core_vld`, `core_hit` and `core_state` are valid one clock after the cycle in which the request was not stalled.
- R3: A qualified snoop that arrives while `tw_en` is high does no lookup and is retried. `tw_en` writes tag and state into `tw_way` of the set selected by `tw_addr`.
- R4: A qualified snoop that arrives while `burst_busy` is high does no lookup and is retried.
- R5: `snp_retry` and `snp_push` are single-cycle pulses, valid exactly two clocks after the qualifying transfer start. Only one snoop is in flight at a time. A qualified transfer start in either of the two cycles after an accepted snoop is retried and does no lookup.
- R6: A snoop that hits a modified line whose line address matches `cb_addr` while `cb_busy` is high is retried. It causes no push and no state change. `co_boost` rises with that retry and stays high until a cycle with `cb_grant` high, after which it falls.
- R7: A snoop that hits a modified line (state 2'b11), and is not blocked as in R6, is retried. `snp_push` is asserted with the hit way on `snp_push_way`. The line becomes exclusive (2'b01) for a read (`bus_type` 2'b00) and invalid (2'b00) for any other type (write 2'b01, intent-to-modify 2'b10 or 2'b11).
- R8: A snoop that hits an exclusive line causes no retry. The line becomes invalid for write and intent-to-modify types and stays exclusive for a read.
- R9: A qualified snoop that misses in the tags produces no retry, no push and no state change.
- R10: A core lookup reports a hit and the line's state from before the lookup. A core store (`core_st` high) that hits an exclusive line makes it modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all lines invalid |
| bus_ts | input | 1 | Bus transfer start |
| bus_gbl | input | 1 | Global (shared memory) attribute |
| bus_addr | input | 32 | Snooped physical address |
| bus_type | input | 2 | 00 read, 01 write, 10/11 read with intent to modify |
| core_req | input | 1 | Core tag lookup request (held while stalled) |
| core_st | input | 1 | Core lookup is a store |
| core_addr | input | 32 | Core lookup address |
| core_stall | output | 1 | Core request lost the tag port this cycle |
| core_vld | output | 1 | Core lookup result valid |
| core_hit | output | 1 | Core lookup hit |
| core_state | output | 2 | State of the hit line (00 when missing) |
| tw_en | input | 1 | Tag write (line install) this cycle |
| tw_addr | input | 32 | Address of the installed line |
| tw_way | input | 2 | Way being written |
| tw_state | input | 2 | State written with the tag |
| burst_busy | input | 1 | Cache busy with a burst read or write |
| cb_busy | input | 1 | Copyback buffer holds a cast-out |
| cb_addr | input | 32 | Address of the line being cast out |
| cb_grant | input | 1 | Cast-out has been granted the bus |
| snp_retry | output | 1 | Retry response for a snoop |
| snp_push | output | 1 | Request to push the snooped modified line |
| snp_push_way | output | 2 | Way to push |
| co_boost | output | 1 | Cast-out raised above the pending fill |

## Verification
Snoop responses have a fixed latency. The bench drives a transfer start in one cycle, checks that `snp_retry` and `snp_push` are still low one clock later, and samples them two clocks later, as R5 specifies. A state change from a snoop takes effect on the clock that ends its lookup cycle. The bench therefore reads line state back through a core lookup, whose result is sampled one clock after its unstalled cycle. `core_stall` is combinational and is sampled within the contested cycle itself. `co_boost` is checked the cycle it rises, while it is held, and the cycle after `cb_grant`.

// File: rtl/snoop_tag_arbiter.sv
module snoop_tag_arbiter #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 128,
  parameter int LINE_B = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ts,
  input  logic              bus_gbl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_type,
  input  logic              core_req,
  input  logic              core_st,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              core_stall,
  output logic              core_vld,
  output logic              core_hit,
  output logic [1:0]        core_state,
  input  logic              tw_en,
  input  logic [ADDR_W-1:0] tw_addr,
  input  logic [$clog2(WAYS)-1:0] tw_way,
  input  logic [1:0]        tw_state,
  input  logic              burst_busy,
  input  logic              cb_busy,
  input  logic [ADDR_W-1:0] cb_addr,
  input  logic              cb_grant,
  output logic              snp_retry,
  output logic              snp_push,
  output logic [$clog2(WAYS)-1:0] snp_push_way,
  output logic              co_boost
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int ENT    = SETS * WAYS;
  localparam logic [1:0] ST_I = 2'b00, ST_E = 2'b01, ST_M = 2'b11;

  logic [TAG_W-1:0] tg [ENT];
  logic [1:0]       st [ENT];

  logic a1, a2, r1, p1, b1;
  logic [WAY_W-1:0] w1;

  wire qual    = bus_ts & bus_gbl;
  wire in_fl   = a1 | a2;
  wire snp_go  = qual & ~in_fl & ~tw_en & ~burst_busy;
  wire core_go = core_req & ~snp_go & ~tw_en;
  assign core_stall = core_req & ~core_go;

  wire [ADDR_W-1:0] lk_addr = snp_go ? bus_addr : core_addr;
  wire [IDX_W-1:0]  lk_idx  = lk_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  lk_tag  = lk_addr[ADDR_W-1:TAG_LO];

  logic             hit;
  logic [WAY_W-1:0] hway;
  logic [1:0]       hst;
  always_comb begin
    hit = 1'b0; hway = '0; hst = ST_I;
    for (int w = 0; w < WAYS; w++) begin
      if (st[lk_idx*WAYS + w] != ST_I && tg[lk_idx*WAYS + w] == lk_tag) begin
        hit = 1'b1; hway = WAY_W'(w); hst = st[lk_idx*WAYS + w];
      end
    end
  end

  wire kill   = bus_type != 2'b00;
  wire co_hit = snp_go & hit & (hst == ST_M) & cb_busy &
                (cb_addr[ADDR_W-1:OFF_W] == bus_addr[ADDR_W-1:OFF_W]);
  wire m_svc  = snp_go & hit & (hst == ST_M) & ~co_hit;
  wire e_kill = snp_go & hit & (hst == ST_E) & kill;
  wire rty    = qual & (in_fl | tw_en | burst_busy | co_hit | m_svc);
  wire [WAY_W-1:0] tw_w = tw_way;
  wire [IDX_W-1:0] tw_idx = tw_addr[OFF_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) st[i] <= ST_I;
    end else if (tw_en) begin
      st[tw_idx*WAYS + int'(tw_w)] <= tw_state;
      tg[tw_idx*WAYS + int'(tw_w)] <= tw_addr[ADDR_W-1:TAG_LO];
    end else if (m_svc | e_kill) begin
      st[lk_idx*WAYS + int'(hway)] <= (m_svc & ~kill) ? ST_E : ST_I;
    end else if (core_go & core_st & hit & (hst == ST_E)) begin
      st[lk_idx*WAYS + int'(hway)] <= ST_M;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {a1, a2, r1, p1, b1, snp_retry, snp_push, co_boost} <= '0;
      {core_vld, core_hit} <= '0;
      w1 <= '0; snp_push_way <= '0; core_state <= ST_I;
    end else begin
      a1 <= qual & ~in_fl;
      a2 <= a1;
      r1 <= rty;
      p1 <= m_svc;
      w1 <= hway;
      b1 <= co_hit;
      snp_retry    <= r1;
      snp_push     <= p1;
      snp_push_way <= p1 ? w1 : '0;
      co_boost     <= b1 | (co_boost & ~cb_grant);
      core_vld     <= core_go;
      core_hit     <= core_go & hit;
      core_state   <= (core_go & hit) ? hst : ST_I;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_unqual_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(bus_ts && bus_gbl, 2)) |-> (!snp_retry && !snp_push));
  p_tw_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(bus_ts && bus_gbl && tw_en, 2)) |-> snp_retry);
  p_burst_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(bus_ts && bus_gbl && burst_busy, 2)) |-> snp_retry);
  p_push_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_push |-> snp_retry);
  p_boost_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (co_boost && !cb_grant) |=> co_boost);
endmodule

// File: tb/tb_snoop_tag_arbiter.sv
module tb_snoop_tag_arbiter;
  logic clk = 0, rst_n = 0;
  logic bus_ts = 0, bus_gbl = 0; logic [31:0] bus_addr = 0; logic [1:0] bus_type = 0;
  logic core_req = 0, core_st = 0; logic [31:0] core_addr = 0;
  logic core_stall, core_vld, core_hit; logic [1:0] core_state;
  logic tw_en = 0; logic [31:0] tw_addr = 0; logic [1:0] tw_way = 0, tw_state = 0;
  logic burst_busy = 0, cb_busy = 0, cb_grant = 0; logic [31:0] cb_addr = 0;
  logic snp_retry, snp_push, co_boost; logic [1:0] snp_push_way;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  snoop_tag_arbiter dut (.*);

  function automatic [31:0] la(input int t, input int i);
    return {t[19:0], i[6:0], 5'b0};
  endfunction

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic install(input [31:0] a, input [1:0] w, input [1:0] s);
    @(negedge clk); tw_en = 1; tw_addr = a; tw_way = w; tw_state = s;
    @(negedge clk); tw_en = 0;
  endtask

  task automatic look(input [31:0] a, input logic store, output logic h, output [1:0] s);
    logic stl;
    @(negedge clk); core_req = 1; core_st = store; core_addr = a;
    do begin #1 stl = core_stall; @(negedge clk); end while (stl);
    core_req = 0; core_st = 0;
    h = core_hit; s = core_state;
  endtask

  task automatic snoop(input [31:0] a, input [1:0] ty, input logic g,
                       output logic r, output logic p, output [1:0] w);
    @(negedge clk); bus_ts = 1; bus_gbl = g; bus_addr = a; bus_type = ty;
    @(negedge clk); bus_ts = 0; bus_gbl = 0;
    chk("R5 early", {snp_retry, snp_push}, 0);
    @(negedge clk); r = snp_retry; p = snp_push; w = snp_push_way;
    @(negedge clk);
    chk("R5 pulse", snp_retry, 0);
  endtask

  task automatic t_reset;
    chk("R5 reset retry", snp_retry, 0); chk("R7 reset push", snp_push, 0);
    chk("R6 reset boost", co_boost, 0); chk("R2 reset stall", core_stall, 0);
    chk("R2 reset vld", core_vld, 0);
  endtask

  task automatic t_core;
    logic h; logic [1:0] s;
    install(la(1, 3), 0, 2'b01); install(la(2, 3), 1, 2'b11);
    look(la(1, 3), 0, h, s); chk("R10 hit E", {h, s}, {1'b1, 2'b01});
    look(la(2, 3), 0, h, s); chk("R10 hit M", {h, s}, {1'b1, 2'b11});
    look(la(3, 3), 0, h, s); chk("R10 miss", {h, s}, 0);
    install(la(7, 20), 3, 2'b01);
    look(la(7, 20), 1, h, s); chk("R10 store on E", s, 2'b01);
    look(la(7, 20), 0, h, s); chk("R10 E to M", s, 2'b11);
  endtask

  task automatic t_unqual;
    logic r, p, h; logic [1:0] w, s;
    snoop(la(2, 3), 2'b01, 0, r, p, w); chk("R1 no gbl retry", {r, p}, 0);
    @(negedge clk); bus_gbl = 1; bus_addr = la(2, 3); bus_type = 2'b01;
    @(negedge clk); bus_gbl = 0;
    @(negedge clk); chk("R1 gbl only retry", snp_retry, 0);
    look(la(2, 3), 0, h, s); chk("R1 state kept", s, 2'b11);
  endtask

  task automatic t_excl;
    logic r, p, h; logic [1:0] w, s;
    snoop(la(1, 3), 2'b00, 1, r, p, w); chk("R8 E read no retry", {r, p}, 0);
    look(la(1, 3), 0, h, s); chk("R8 E read stays", s, 2'b01);
    snoop(la(1, 3), 2'b01, 1, r, p, w); chk("R8 E write no retry", r, 0);
    look(la(1, 3), 0, h, s); chk("R8 E write invalid", h, 0);
  endtask

  task automatic t_mod;
    logic r, p, h; logic [1:0] w, s;
    snoop(la(2, 3), 2'b00, 1, r, p, w);
    chk("R7 M read retry/push", {r, p, w}, {2'b11, 2'd1});
    look(la(2, 3), 0, h, s); chk("R7 M read to E", s, 2'b01);
    install(la(5, 10), 2, 2'b11);
    snoop(la(5, 10), 2'b10, 1, r, p, w);
    chk("R7 M rwitm retry/push", {r, p, w}, {2'b11, 2'd2});
    look(la(5, 10), 0, h, s); chk("R7 M rwitm invalid", h, 0);
  endtask

  task automatic t_miss;
    logic r, p; logic [1:0] w;
    snoop(la(99, 77), 2'b01, 1, r, p, w); chk("R9 miss quiet", {r, p}, 0);
  endtask

  task automatic t_contend;
    install(la(30, 33), 2, 2'b01);
    @(negedge clk); bus_ts = 1; bus_gbl = 1; bus_addr = la(99, 70); bus_type = 0;
    core_req = 1; core_addr = la(30, 33);
    #1 chk("R2 stall on snoop", core_stall, 1);
    @(negedge clk); bus_ts = 0; bus_gbl = 0;
    chk("R2 no result while stalled", core_vld, 0);
    #1 chk("R2 proceeds next", core_stall, 0);
    @(negedge clk); core_req = 0;
    chk("R2 result", {core_vld, core_hit, core_state}, {2'b11, 2'b01});
    chk("R9 contended miss", snp_retry, 0);
  endtask

  task automatic t_twcol;
    logic h; logic [1:0] s;
    install(la(14, 61), 0, 2'b01);
    @(negedge clk); bus_ts = 1; bus_gbl = 1; bus_addr = la(14, 61); bus_type = 2'b01;
    tw_en = 1; tw_addr = la(15, 62); tw_way = 1; tw_state = 2'b01;
    @(negedge clk); bus_ts = 0; bus_gbl = 0; tw_en = 0;
    @(negedge clk); chk("R3 tag-write retry", snp_retry, 1);
    look(la(14, 61), 0, h, s); chk("R3 no lookup", s, 2'b01);
    look(la(15, 62), 0, h, s); chk("R3 install", {h, s}, {1'b1, 2'b01});
  endtask

  task automatic t_burst;
    logic r, p, h; logic [1:0] w, s;
    install(la(13, 60), 0, 2'b01);
    burst_busy = 1;
    snoop(la(13, 60), 2'b01, 1, r, p, w);
    burst_busy = 0;
    chk("R4 burst retry", r, 1);
    look(la(13, 60), 0, h, s); chk("R4 no lookup", s, 2'b01);
  endtask

  task automatic t_inflight;
    logic h; logic [1:0] s;
    install(la(11, 50), 1, 2'b11);
    @(negedge clk); bus_ts = 1; bus_gbl = 1; bus_addr = la(99, 90); bus_type = 0;
    @(negedge clk); bus_addr = la(11, 50); bus_type = 2'b01;
    @(negedge clk); bus_ts = 0; bus_gbl = 0;
    chk("R5 first miss", snp_retry, 0);
    @(negedge clk); chk("R5 in-flight retry", {snp_retry, snp_push}, 2'b10);
    @(negedge clk); chk("R5 single pulse", snp_retry, 0);
    look(la(11, 50), 0, h, s); chk("R5 no lookup", s, 2'b11);
  endtask

  task automatic t_castout;
    logic r, p, h; logic [1:0] w, s;
    install(la(9, 40), 0, 2'b11);
    cb_busy = 1; cb_addr = la(9, 40) | 32'h4;
    snoop(la(9, 40), 2'b00, 1, r, p, w);
    chk("R6 castout retry no push", {r, p}, 2'b10);
    chk("R6 boost held", co_boost, 1);
    repeat (3) @(negedge clk);
    chk("R6 boost still held", co_boost, 1);
    cb_grant = 1; @(negedge clk); cb_grant = 0; cb_busy = 0;
    chk("R6 boost cleared", co_boost, 0);
    look(la(9, 40), 0, h, s); chk("R6 state kept", s, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_core(); t_unqual(); t_excl(); t_mod(); t_miss(); t_contend();
    t_twcol(); t_burst(); t_inflight(); t_castout();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule